// File: doc/BRIEF.md
# Bidirectional I/O Port with Pull-up Control

This block is one eight-pin general-purpose I/O port. Software sees three registers through a small write/read interface: an output-level register, a direction register and a read-only register of sampled pin levels. Every bit of each register belongs to one pin. The port sends the output level, the output enable and a pull-up request for each pin to the pad ring.

The output-level register has two uses. A pin whose direction bit is 1 is an output and is driven with its level bit. A pin whose direction bit is 0 is an input, and its level bit then requests the weak pull-up. A chip-wide pull-up disable input overrides every pull-up request. A chip-wide sleep input gates the input path to zero, which models input buffers that are switched off. Pin levels reach the readable pin register through a synchronizer whose depth is a parameter (two by default).

Top module: `gpio_port`

## Requirements
- R1: After reset the output-level, direction and pin registers read 0, and `pad_oe` and `pad_pu` are 0. Every pin is then an input with no pull-up.
- R2: A write with `reg_sel` = 0 loads `wdata` into the output-level register at the clock edge. From the next cycle `pad_out` equals that value, and so does a read with `reg_sel` = 0.
- R3: A write with `reg_sel` = 1 loads the direction register. A bit set to 1 makes the pin an output, so `pad_oe` equals the register, and a read with `reg_sel` = 1 returns it.
- R4: `pad_pu[i]` is 1 exactly when direction bit i is 0, level bit i is 1 and `pull_dis` is 0.
- R5: While `pull_dis` is 1, `pad_pu` is 0 on every pin. An output pin never has its pull-up enabled.
- R6: A read with `reg_sel` = 2 returns the `pin_in` levels sampled two clock edges earlier. It does not return the output-level register.
- R7: While `sleep` is 1 the sampled input is forced to 0. Once sleep has been held for two edges, the pin register reads all zeros, whatever `pin_in` is.
- R8: A write with `reg_sel` = 2 (pin register) or 3 (unused) changes no register. A read with `reg_sel` = 3 returns 0.
- R9: While `wr_en` is 0, the output-level and direction registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 output level, 1 direction, 2 pin, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| pull_dis | input | 1 | Chip-wide pull-up disable |
| sleep | input | 1 | Chip-wide sleep, gates the input path |
| pad_out | output | 8 | Output level per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
On every cycle the assertions check the following: register writes reach the pad outputs one edge later, ignored writes and idle cycles leave the pads unchanged, pull-ups stay off under the disable and on output pins, and the pin register follows the input two edges behind or reads zero after sleep. The reset state needs a bench scenario, and so does the full pull-up truth table over many direction and level patterns. The bench also shows that the pin read is independent of the output-level register and that a level change is still invisible after only one edge.

// File: rtl/gpio_port_pkg.sv
// Shared register-select encoding for the I/O port.
// Assumes a two-bit select field on the register interface.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PIN   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
// Output-level and direction registers of the port.
// Assumes writes are single-cycle strobes; pin and unused selects are ignored.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level_q,
    output logic [W-1:0] dir_q
);
    // Load the selected writable register; reset makes every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(sel))
                SEL_LEVEL: level_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_insync.sv
// Input path: sleep gating followed by a multi-stage synchronizer.
// Assumes pin levels are asynchronous to clk; the last stage is the pin register.
module gpio_port_insync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_q
);
    logic [W-1:0] gated;
    logic [W-1:0] stg [STAGES];

    // Disabled input buffers present a constant zero during sleep.
    always_comb gated = sleep ? '0 : pin_i;

    // Shift the gated levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= gated;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign pin_q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_padctl.sv
// Per-pin pad controls: output level, output enable and pull-up request.
// Assumes the level register doubles as pull-up select on input pins.
module gpio_port_padctl #(
    parameter int W = 8
) (
    input  logic         pull_dis,
    input  logic [W-1:0] level,
    input  logic [W-1:0] dir,
    output logic [W-1:0] out_o,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] pu_o
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign out_o[i] = level[i];
        assign oe_o[i]  = dir[i];
        assign pu_o[i]  = !dir[i] && level[i] && !pull_dis;
    end
endmodule

// File: rtl/gpio_port.sv
// Top of the I/O port: register bank, input synchronizer, pad control and read mux.
// Assumes a combinational read of the selected register.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    input  logic         pull_dis,
    input  logic         sleep,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    logic [W-1:0] level_q, dir_q, pin_q;

    gpio_port_regs #(.W(W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(reg_sel),
        .wdata(wdata), .level_q(level_q), .dir_q(dir_q)
    );

    gpio_port_insync #(.W(W), .STAGES(STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .pin_i(pin_in), .pin_q(pin_q)
    );

    gpio_port_padctl #(.W(W)) i_pad (
        .pull_dis(pull_dis), .level(level_q), .dir(dir_q),
        .out_o(pad_out), .oe_o(pad_oe), .pu_o(pad_pu)
    );

    // Return the selected register; the unused select reads zero.
    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_LEVEL: rdata = level_q;
            SEL_DIR:   rdata = dir_q;
            SEL_PIN:   rdata = pin_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Property checker for the I/O port, bound to every gpio_port instance.
module gpio_port_chk #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   reg_sel,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pin_in,
    input logic         pull_dis,
    input logic         sleep,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2
    level_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0) |=> (pad_out == $past(wdata)));

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1) |=> (pad_oe == $past(wdata)));

    // R5
    pull_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dis |-> (pad_pu == '0));

    // R5
    pull_not_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel[1]) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_out) && $stable(pad_oe)));

    if (STAGES == 2) begin : g_two_stage
        // R6
        pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2 && reg_sel == 2'd2 && !$past(sleep, 2))
                |-> (rdata == $past(pin_in, 2)));

        // R7
        sleep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2 && reg_sel == 2'd2 && $past(sleep, 2))
                |-> (rdata == '0));
    end
endmodule

bind gpio_port gpio_port_chk #(.W(W), .STAGES(STAGES)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pull_dis(pull_dis), .sleep(sleep),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic       pull_dis = 1'b0;
    logic       sleep = 1'b0;
    logic [7:0] pad_out, pad_oe, pad_pu;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pull_dis(pull_dis), .sleep(sleep),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        reg_sel = sel;
        #0.5 d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, r); check("R1 level", r, 8'h00);
        rd(2'd1, r); check("R1 dir", r, 8'h00);
        rd(2'd2, r); check("R1 pin", r, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h00);

        // R2 R3 R4 R5 sweep over level, direction and pull-up disable
        for (int d = 0; d < 256; d += 17) begin
            for (int m = 0; m < 256; m += 51) begin
                @(negedge clk);
                wr(2'd0, 8'(d));
                wr(2'd1, 8'(m));
                check("R2 pad_out", pad_out, 8'(d));
                rd(2'd0, r); check("R2 readback", r, 8'(d));
                check("R3 pad_oe", pad_oe, 8'(m));
                rd(2'd1, r); check("R3 readback", r, 8'(m));
                for (int p = 0; p < 2; p++) begin
                    pull_dis = p[0];
                    #0.5;
                    if (p == 0) check("R4 pull-up", pad_pu, ~8'(m) & 8'(d));
                    else        check("R5 pull disable", pad_pu, 8'h00);
                end
                pull_dis = 1'b0;
            end
        end

        // R9 idle cycles hold
        @(negedge clk);
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        wdata = 8'hFF; reg_sel = 2'd0;
        repeat (3) @(negedge clk);
        check("R9 level hold", pad_out, 8'hA5);
        check("R9 dir hold", pad_oe, 8'h3C);

        // R8 writes to pin and unused selects ignored
        wr(2'd2, 8'h11);
        wr(2'd3, 8'h22);
        check("R8 level", pad_out, 8'hA5);
        check("R8 dir", pad_oe, 8'h3C);
        rd(2'd3, r); check("R8 unused read", r, 8'h00);

        // R6 pin sweep: all levels, two-edge latency, independent of level reg
        wr(2'd0, 8'h5A);
        for (int v = 0; v < 256; v++) begin
            pin_in = 8'(v);
            @(negedge clk);
            if (v % 32 == 1) begin
                rd(2'd2, r); check("R6 one edge old", r, 8'(v - 1));
            end
            @(negedge clk);
            rd(2'd2, r); check("R6 pin read", r, 8'(v));
        end

        // R7 sleep gates input to zero, recovers after wake
        pin_in = 8'hC3;
        repeat (2) @(negedge clk);
        sleep = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd2, r); check("R7 sleep zero", r, 8'h00);
        pin_in = 8'hFF;
        repeat (3) @(negedge clk);
        rd(2'd2, r); check("R7 sleep held", r, 8'h00);
        sleep = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd2, r); check("R7 wake", r, 8'hFF);

        // R1 reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, r); check("R1 level after reset", r, 8'h00);
        check("R1 oe after reset", pad_oe, 8'h00);
        rd(2'd2, r); check("R1 pin after reset", r, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule